// File: doc/BRIEF.md
# Embedded Controller Mailbox Host Port

This block is the device end of a byte-wide mailbox. A host uses it to reach a 256-byte register space that lies behind the block. The host sees two ports. The data port sits at offset 0. The port at offset 4 reads as status and takes command bytes when written. Every host write raises an input-busy flag. The flag drops when the block has taken the byte. A host therefore polls that flag before each byte it sends.

A read runs as a read command followed by one address byte. The block then fetches that register and places it in the data port, and it raises an output-ready flag. A write runs as a write command, then an address byte, then a data byte. After the data byte the block performs one store into the register space. The register space is reached through a plain synchronous interface. A read strobe returns its data on the next clock, and a write strobe stores in the same clock.

Input-busy stays set for a fixed number of cycles, set by `IBF_CYCLES`. This gives host polling code a delay it can observe and measure.

Top module: `ecmb_host_port`

## Requirements
- R1: Offset bit 2 of `host_off` selects the port. When it is 0, `host_rdata` is the data-port byte and a write is a data byte. When it is 1, `host_rdata` is status and a write is a command byte. In the status byte, bit 1 is input-busy, bit 0 is output-ready, and bits 7..2 read 0.
- R2: A host write to either port sets input-busy on the next cycle. While the block is waiting for a byte, the flag stays set for exactly `IBF_CYCLES` cycles and then clears. A second write made while the flag is set replaces the pending byte and restarts the count.
- R3: Command 0x80 followed by an address byte causes exactly one register-space read of that address. Two cycles after the read strobe, output-ready is set and the data port holds the register's value.
- R4: Command 0x81, an address byte and a data byte cause exactly one register-space write of that data to that address. No read is issued.
- R5: A host read of the data port (`host_rd` with offset bit 2 at 0) clears output-ready on the next cycle. Reading status does not change it.
- R6: A data byte written while no command is in progress causes no register access. It also leaves output-ready and the data port unchanged.
- R7: A command byte that arrives in the middle of a sequence discards the partial sequence, and decoding restarts from the new command.
- R8: Any command byte other than 0x80 or 0x81 is consumed, and input-busy clears. It leaves no command in progress and has no other effect.
- R9: After reset, status reads 0x00, the data port reads 0x00, and no register access is issued.
- R10: A register read strobe and a register write strobe are never both asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_off | input | 3 | Host port offset; bit 2 selects status/command |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Byte presented to the host for the selected port |
| reg_addr | output | 8 | Register-space address |
| reg_wdata | output | 8 | Register-space write data |
| reg_we | output | 1 | Register-space write strobe |
| reg_re | output | 1 | Register-space read strobe |
| reg_rdata | input | 8 | Register-space read data, valid the cycle after `reg_re` |

## Verification
The bench counts the read and write strobes on the register side, and it also compares the values that come back through the data port. A wrong decoder state therefore shows at the ports within one sequence. A sequencer that was not reset by an abort, or by an unknown command, turns later stray data bytes into strobes that the bench can count. A lost address or data byte returns the wrong value, or stores to the wrong place, on the next read-back. A timer fault shows on the status port within `IBF_CYCLES` cycles of a write, as a busy period of the wrong length. A fault in the output flag shows one cycle after a data-port read.

// File: rtl/ecmb_pkg.sv
package ecmb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_READ  = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h81;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RADDR,
    S_WADDR,
    S_WDATA,
    S_FETCH,
    S_CAPT,
    S_STORE
  } seq_state_e;
endpackage

// File: rtl/ecmb_inbox.sv
module ecmb_inbox
  import ecmb_pkg::*;
#(
  parameter int IBF_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              wr_is_cmd,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              accept,
  output logic              ibf,
  output logic              consume,
  output logic              held_is_cmd,
  output logic [BYTE_W-1:0] held_byte
);
  localparam int CNT_W = (IBF_CYCLES > 1) ? $clog2(IBF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(IBF_CYCLES - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ibf_d;
  logic              cmd_d;
  logic [BYTE_W-1:0] byte_d;

  assign consume = ibf && (cnt_q == '0) && accept && !wr_stb;

  always_comb begin
    cnt_d  = cnt_q;
    ibf_d  = ibf;
    cmd_d  = held_is_cmd;
    byte_d = held_byte;
    if (wr_stb) begin
      ibf_d  = 1'b1;
      cnt_d  = CNT_LOAD;
      cmd_d  = wr_is_cmd;
      byte_d = wr_byte;
    end else if (consume) begin
      ibf_d = 1'b0;
    end else if (ibf && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      ibf         <= 1'b0;
      held_is_cmd <= 1'b0;
      held_byte   <= '0;
    end else begin
      cnt_q       <= cnt_d;
      ibf         <= ibf_d;
      held_is_cmd <= cmd_d;
      held_byte   <= byte_d;
    end
  end

  p_ibf_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ibf);
  p_ibf_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && !consume) |=> ibf);
  p_consume_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !ibf);
endmodule

// File: rtl/ecmb_outbox.sv
module ecmb_outbox
  import ecmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              host_take,
  output logic              obf,
  output logic [BYTE_W-1:0] dout
);
  logic              obf_d;
  logic [BYTE_W-1:0] dout_d;

  always_comb begin
    obf_d  = obf;
    dout_d = dout;
    if (load) begin
      obf_d  = 1'b1;
      dout_d = load_byte;
    end else if (host_take) begin
      obf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf  <= 1'b0;
      dout <= '0;
    end else begin
      obf  <= obf_d;
      dout <= dout_d;
    end
  end

  p_obf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_take && !load) |=> !obf);
  p_dout_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dout));
endmodule

// File: rtl/ecmb_seq.sv
module ecmb_seq
  import ecmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              consume,
  input  logic              is_cmd,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              accept,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] acc_addr,
  output logic [BYTE_W-1:0] acc_data,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte
);
  seq_state_e        state_q, state_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] data_q, data_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    data_d  = data_q;
    if (consume && is_cmd) begin
      if (in_byte == CMD_READ)       state_d = S_RADDR;
      else if (in_byte == CMD_WRITE) state_d = S_WADDR;
      else                           state_d = S_IDLE;
    end else begin
      case (state_q)
        S_RADDR: if (consume) begin addr_d = in_byte; state_d = S_FETCH; end
        S_WADDR: if (consume) begin addr_d = in_byte; state_d = S_WDATA; end
        S_WDATA: if (consume) begin data_d = in_byte; state_d = S_STORE; end
        S_FETCH: state_d = S_CAPT;
        S_CAPT:  state_d = S_IDLE;
        S_STORE: state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign accept    = (state_q == S_IDLE) || (state_q == S_RADDR) ||
                     (state_q == S_WADDR) || (state_q == S_WDATA);
  assign rd_stb    = (state_q == S_FETCH);
  assign wr_stb    = (state_q == S_STORE);
  assign acc_addr  = addr_q;
  assign acc_data  = data_q;
  assign load      = (state_q == S_CAPT);
  assign load_byte = rd_byte;

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  p_store_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |-> $past(consume && !is_cmd));
  p_unknown_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && is_cmd && in_byte != CMD_READ && in_byte != CMD_WRITE)
      |=> (state_q == S_IDLE));
  p_stray_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !(consume && is_cmd)) |=> (state_q == S_IDLE));
endmodule

// File: rtl/ecmb_host_port.sv
module ecmb_host_port
  import ecmb_pkg::*;
#(
  parameter int IBF_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] host_off,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);
  logic [1:0]        rst_sync;
  logic              rst_n_s;
  logic              ibf, obf, consume, accept, held_cmd, load;
  logic [BYTE_W-1:0] held_byte, dout, load_byte;
  logic              sel_status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s    = rst_sync[1];
  assign sel_status = host_off[2];

  ecmb_inbox #(.IBF_CYCLES(IBF_CYCLES)) u_inbox (
    .clk(clk), .rst_n(rst_n_s),
    .wr_stb(host_wr), .wr_is_cmd(sel_status), .wr_byte(host_wdata),
    .accept(accept), .ibf(ibf), .consume(consume),
    .held_is_cmd(held_cmd), .held_byte(held_byte)
  );

  ecmb_seq u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .consume(consume), .is_cmd(held_cmd), .in_byte(held_byte),
    .rd_byte(reg_rdata), .accept(accept),
    .rd_stb(reg_re), .wr_stb(reg_we),
    .acc_addr(reg_addr), .acc_data(reg_wdata),
    .load(load), .load_byte(load_byte)
  );

  ecmb_outbox u_outbox (
    .clk(clk), .rst_n(rst_n_s),
    .load(load), .load_byte(load_byte),
    .host_take(host_rd && !sel_status),
    .obf(obf), .dout(dout)
  );

  assign host_rdata = sel_status ? {6'b0, ibf, obf} : dout;

  p_read_gives_obf_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_re |=> ##1 obf);
  p_status_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    sel_status |-> (host_rdata[7:2] == 6'b0));
endmodule

// File: tb/tb_ecmb_host_port.sv
module tb_ecmb_host_port;
  localparam int NCYC = 4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_off = 3'd0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_re;

  int checks = 0, failures = 0;
  bit done = 0;
  int re_cnt = 0, we_cnt = 0;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];

  always #4 clk = ~clk;

  ecmb_host_port #(.IBF_CYCLES(NCYC)) dut (
    .clk(clk), .rst_n(rst_n), .host_off(host_off), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  initial for (int i = 0; i < 256; i++) begin
    mem[i]     = 8'((i * 7 + 3) & 8'hff);
    exp_mem[i] = 8'((i * 7 + 3) & 8'hff);
  end

  always_ff @(posedge clk) begin
    if (reg_re) begin reg_rdata <= mem[reg_addr]; re_cnt <= re_cnt + 1; end
    if (reg_we) begin mem[reg_addr] <= reg_wdata; we_cnt <= we_cnt + 1; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] off, input logic [7:0] v);
    @(negedge clk);
    host_off = off; host_wdata = v; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_off = 3'd4;
  endtask

  task automatic status(output logic [7:0] s);
    host_off = 3'd4; #1; s = host_rdata;
  endtask

  task automatic wait_ibf(input string req);
    logic [7:0] s;
    int n = 0;
    status(s);
    while (s[1] && n < 500) begin @(negedge clk); status(s); n++; end
    chk(req, {31'd0, s[1]}, 32'd0);
  endtask

  task automatic wait_obf(input string req);
    logic [7:0] s;
    int n = 0;
    status(s);
    while (!s[0] && n < 500) begin @(negedge clk); status(s); n++; end
    chk(req, {31'd0, s[0]}, 32'd1);
  endtask

  task automatic read_data(output logic [7:0] v);
    @(negedge clk);
    host_off = 3'd0; host_rd = 1'b1; #1; v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0; host_off = 3'd4;
  endtask

  task automatic send(input logic [2:0] off, input logic [7:0] v, input string req);
    wait_ibf(req);
    hwrite(off, v);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    status(s);
    chk("R9 status", {24'd0, s}, 32'h00);
    host_off = 3'd0; #1;
    chk("R9 data", {24'd0, host_rdata}, 32'h00);
    chk("R9 no access", re_cnt + we_cnt, 0);
  endtask

  task automatic t_ibf_timing;
    logic [7:0] s;
    int n;
    hwrite(3'd4, 8'h80);
    n = 0; status(s);
    while (s[1] && n < 100) begin n++; @(negedge clk); status(s); end
    chk("R2 busy length cmd", n, NCYC);
    chk("R1 status bits", {24'd0, s}, 32'h00);
    hwrite(3'd0, 8'h05);
    hwrite(3'd0, 8'h06);
    n = 0; status(s);
    while (s[1] && n < 100) begin n++; @(negedge clk); status(s); end
    chk("R2 restart count", n, NCYC);
    wait_obf("R3 obf after replaced addr");
    host_off = 3'd0; #1;
    chk("R2 replaced byte used", {24'd0, host_rdata}, {24'd0, exp_mem[6]});
    begin logic [7:0] v; read_data(v); end
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    logic [7:0] v, s;
    int r0;
    r0 = re_cnt;
    send(3'd4, 8'h80, req);
    send(3'd0, a, req);
    wait_obf(req);
    status(s);
    @(negedge clk); status(s);
    chk({req, " status read keeps obf R5"}, {31'd0, s[0]}, 32'd1);
    read_data(v);
    chk({req, " data"}, {24'd0, v}, {24'd0, exp_mem[a]});
    chk({req, " one read R10"}, re_cnt - r0, 1);
    status(s);
    chk({req, " obf cleared R5"}, {31'd0, s[0]}, 32'd0);
  endtask

  task automatic t_read;
    do_read(8'h00, "R3 addr00");
    do_read(8'hFF, "R3 addrFF");
    do_read(8'h3C, "R3 addr3C");
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string req);
    int w0, r0;
    w0 = we_cnt; r0 = re_cnt;
    send(3'd4, 8'h81, req);
    send(3'd0, a, req);
    send(3'd0, d, req);
    wait_ibf(req);
    repeat (3) @(negedge clk);
    exp_mem[a] = d;
    chk({req, " one write"}, we_cnt - w0, 1);
    chk({req, " no read"}, re_cnt - r0, 0);
  endtask

  task automatic t_write;
    do_write(8'h10, 8'hA5, "R4 addr10");
    do_read(8'h10, "R4 readback10");
    do_write(8'hFF, 8'h5A, "R4 addrFF");
    do_read(8'hFF, "R4 readbackFF");
  endtask

  task automatic t_ignored;
    int a0;
    logic [7:0] s;
    a0 = re_cnt + we_cnt;
    send(3'd0, 8'h22, "R6");
    send(3'd0, 8'h33, "R6");
    wait_ibf("R6");
    repeat (4) @(negedge clk);
    chk("R6 no access", re_cnt + we_cnt - a0, 0);
    status(s);
    chk("R6 obf unchanged", {31'd0, s[0]}, 32'd0);
    host_off = 3'd0; #1;
    chk("R6 data unchanged", {24'd0, host_rdata}, {24'd0, exp_mem[8'hFF]});
  endtask

  task automatic t_abort;
    int w0, r0;
    w0 = we_cnt;
    send(3'd4, 8'h81, "R7");
    send(3'd0, 8'h20, "R7");
    do_read(8'h20, "R7 abort write");
    chk("R7 aborted write absent", we_cnt - w0, 0);
    r0 = re_cnt;
    send(3'd4, 8'h80, "R7");
    do_write(8'h21, 8'h99, "R7 abort read");
    chk("R7 aborted read absent", re_cnt - r0, 0);
    do_read(8'h21, "R7 readback");
  endtask

  task automatic t_unknown;
    int a0;
    a0 = re_cnt + we_cnt;
    send(3'd4, 8'h42, "R8");
    wait_ibf("R8 consumed");
    send(3'd0, 8'h30, "R8");
    send(3'd0, 8'h31, "R8");
    wait_ibf("R8");
    repeat (4) @(negedge clk);
    chk("R8 no effect", re_cnt + we_cnt - a0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ibf_timing();
    t_read();
    t_write();
    t_ignored();
    t_abort();
    t_unknown();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule